// File: doc/BRIEF.md
# Write-Only Two-Wire Voltage-Code Receiver

This block sits on the system clock and listens to an I2C bus as a slave that only accepts writes. Both bus lines pass through a synchronizer and are oversampled. The block recognises START and STOP conditions and compares the first byte of each transfer against a fixed device address. When a write is addressed to it, it captures one data byte. The low five bits of that byte become a new output-voltage code. Code 0 stands for 0.60 V and each step adds 50 mV.

The code register drives a regulator's setpoint. On each accepted write it gives a one-cycle update strobe. While the enable input is low, the register is forced to its default code, which stands for 1.80 V. The block acknowledges on the bus by asserting an open-drain pull-low enable, which the pad turns into a low on SDA.

Top module: `vcode_i2c_slave`

## Requirements
- R1: After reset the code output is 24 (1.80 V), the SDA pull-low output is 0 and the update strobe is 0.
- R2: A first byte equal to 0x28, sent MSB first, is acknowledged: SDA is held low while SCL is high in the ninth clock. That byte is the 7-bit address 0x14 in bits 7..1 with R/W = 0 in bit 0.
- R3: A first byte that carries any other address, or has R/W = 1, is not acknowledged. SDA stays released for the rest of that transfer and the code does not change.
- R4: For an addressed write, the following data byte (MSB first) is acknowledged in its ninth clock. The new code is taken from bits 4..0, and bits 7..5 have no effect on the code.
- R5: Data values 28 to 31 in bits 4..0 are stored as code 28 (2.00 V). The code output never exceeds 28.
- R6: The code is committed only at the SCL falling edge that ends the data byte's acknowledge clock. The strobe then rises for exactly one cycle. A STOP that arrives earlier leaves the code unchanged and gives no strobe.
- R7: Only one data byte is taken per transfer. Any further bytes before STOP are not acknowledged and do not change the code.
- R8: A repeated START in the middle of a transfer drops the partial byte and restarts address reception.
- R9: While enable is low, the code is 24 from the next cycle on and no strobe occurs. Writes received during that time are acknowledged but discarded, and the code is still 24 after enable returns high.
- R10: The SDA pull-low output only rises while the synchronized SCL is low. It is released after the acknowledge clock, so it is 0 at the following STOP and never during a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable; low forces the default code |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| vcode_o | output | 5 | Voltage code, 0.60 V + 50 mV per step |
| vcode_upd_o | output | 1 | One-cycle pulse when a new code is committed |

## Verification
The bound checker watches several properties on every cycle:
- the code never goes above the saturation value;
- the strobe lasts a single cycle;
- the code changes only together with a strobe or a disable;
- enable low pulls the code back to its default;
- the acknowledge pull starts only while SCL is low and is already released when the strobe fires.

Some behaviour depends on whole bus transfers, so only the bench scenarios can show it. That includes matching the address and R/W bit, taking the field from bits 4..0, refusing extra bytes, restarting on a repeated START, and dropping a write cut short by STOP.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_SKIP
    } xfer_state_e;
endpackage

// File: rtl/vcs_sync.sv
module vcs_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] async_i,
    output logic [N_LINES-1:0] sync_o
);
    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= chain_d;
            end

            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/vcs_bus_cond.sv
module vcs_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // SDA edges while SCL holds high mark bus conditions
    assign start_o    = prev_q.scl & scl_s & prev_q.sda & ~sda_s;
    assign stop_o     = prev_q.scl & scl_s & ~prev_q.sda & sda_s;
    assign scl_rise_o = ~prev_q.scl & scl_s;
    assign scl_fall_o = prev_q.scl & ~scl_s;
endmodule

// File: rtl/vcs_xfer_fsm.sv
module vcs_xfer_fsm
    import vcs_pkg::*;
#(
    parameter int          BYTE_W   = 8,
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  DEV_ADDR = 7'h14,
    parameter int          FIELD_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_s,
    output logic               pull_o,
    output logic               commit_o,
    output logic [FIELD_W-1:0] field_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] WR_MATCH = {DEV_ADDR[ADDR_W-1:0], 1'b0};

    typedef struct packed {
        xfer_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shreg;
        logic               pull;
        logic               commit;
        logic [FIELD_W-1:0] field;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.commit = 1'b0;
        if (start_i) begin
            r_d.state = ST_ADDR;
            r_d.cnt   = '0;
            r_d.pull  = 1'b0;
        end else if (stop_i) begin
            r_d.state = ST_IDLE;
            r_d.pull  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise_i && r_q.cnt < CNT_W'(BYTE_W)) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + CNT_W'(1);
                    end else if (scl_fall_i && r_q.cnt == CNT_W'(BYTE_W)) begin
                        if (r_q.state == ST_ADDR) begin
                            if (r_q.shreg == WR_MATCH) begin
                                r_d.state = ST_AACK;
                                r_d.pull  = 1'b1;
                            end else begin
                                r_d.state = ST_SKIP;
                            end
                        end else begin
                            r_d.state = ST_DACK;
                            r_d.pull  = 1'b1;
                            r_d.field = r_q.shreg[FIELD_W-1:0];
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        r_d.pull  = 1'b0;
                        r_d.state = ST_DATA;
                        r_d.cnt   = '0;
                    end
                end
                ST_DACK: begin
                    if (scl_fall_i) begin
                        r_d.pull   = 1'b0;
                        r_d.commit = 1'b1;
                        r_d.state  = ST_SKIP;
                    end
                end
                default: begin
                    r_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, pull: 1'b0,
                     commit: 1'b0, field: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pull_o   = r_q.pull;
    assign commit_o = r_q.commit;
    assign field_o  = r_q.field;
endmodule

// File: rtl/vcs_code_reg.sv
module vcs_code_reg #(
    parameter int CODE_W       = 5,
    parameter int CODE_DEFAULT = 24,
    parameter int CODE_MAX     = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] field_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);
    localparam logic [CODE_W-1:0] DEF_C = CODE_W'(CODE_DEFAULT);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } creg_t;

    creg_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.upd = 1'b0;
        if (!en_i) begin
            c_d.code = DEF_C;
        end else if (commit_i) begin
            c_d.code = (field_i > MAX_C) ? MAX_C : field_i;
            c_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{code: DEF_C, upd: 1'b0};
        else        c_q <= c_d;
    end

    assign code_o = c_q.code;
    assign upd_o  = c_q.upd;
endmodule

// File: rtl/vcode_i2c_slave.sv
module vcode_i2c_slave #(
    parameter int         SYNC_STAGES  = 2,
    parameter logic [6:0] DEV_ADDR     = 7'h14,
    parameter int         CODE_W       = 5,
    parameter int         CODE_DEFAULT = 24,
    parameter int         CODE_MAX     = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [CODE_W-1:0] vcode_o,
    output logic              vcode_upd_o
);
    localparam int BYTE_W = 8;

    logic [1:0]        lines_s;
    logic              scl_s, sda_s;
    logic              start_p, stop_p, scl_rise, scl_fall;
    logic              commit;
    logic [CODE_W-1:0] field;

    vcs_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    vcs_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .start_o    (start_p),
        .stop_o     (stop_p),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    vcs_xfer_fsm #(
        .BYTE_W   (BYTE_W),
        .ADDR_W   (7),
        .DEV_ADDR (DEV_ADDR),
        .FIELD_W  (CODE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_s      (sda_s),
        .pull_o     (sda_pull_o),
        .commit_o   (commit),
        .field_o    (field)
    );

    vcs_code_reg #(
        .CODE_W       (CODE_W),
        .CODE_DEFAULT (CODE_DEFAULT),
        .CODE_MAX     (CODE_MAX)
    ) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .commit_i (commit),
        .field_i  (field),
        .code_o   (vcode_o),
        .upd_o    (vcode_upd_o)
    );
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
    parameter int CODE_W       = 5,
    parameter int CODE_DEFAULT = 24,
    parameter int CODE_MAX     = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              scl_s,
    input logic              sda_pull_o,
    input logic [CODE_W-1:0] vcode_o,
    input logic              vcode_upd_o
);
    // R5: code bounded by the saturation value
    a_r5_code_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_o <= CODE_W'(CODE_MAX));

    // R6: strobe is a single cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_upd_o |=> !vcode_upd_o);

    // R6: code moves only with a strobe or after a disable
    a_r6_code_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode_o != $past(vcode_o)) |-> (vcode_upd_o || !$past(en_i)));

    // R9: disable returns the default and suppresses the strobe
    a_r9_disable_default: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (vcode_o == CODE_W'(CODE_DEFAULT)) && !vcode_upd_o);

    // R10: acknowledge pull begins only while SCL is low
    a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

    // R10: pull already released when a code is committed
    a_r10_released_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_upd_o |-> !sda_pull_o);
endmodule

bind vcode_i2c_slave vcs_checker #(
    .CODE_W       (CODE_W),
    .CODE_DEFAULT (CODE_DEFAULT),
    .CODE_MAX     (CODE_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .scl_s       (scl_s),
    .sda_pull_o  (sda_pull_o),
    .vcode_o     (vcode_o),
    .vcode_upd_o (vcode_upd_o)
);

// File: tb/tb_vcode_i2c_slave.sv
module tb_vcode_i2c_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       pull;
    logic [4:0] code;
    logic       upd;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~pull;

    vcode_i2c_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (pull),
        .vcode_o     (code),
        .vcode_upd_o (upd)
    );

    always @(negedge clk) if (rst_n && upd) strobes++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();  // also serves as repeated START
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b, output logic s);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        bit_out(1'b1, s);
        acked = ~s;
    endtask

    task automatic write_xfer(input logic [7:0] a, input logic [7:0] d,
                              output logic ack_a, output logic ack_d);
        bus_start();
        send_byte(a, ack_a);
        send_byte(d, ack_d);
        bus_stop();
        wq();
    endtask

    function automatic int sat_code(input logic [7:0] d);
        int f = int'(d[4:0]);
        return (f > 28) ? 28 : f;
    endfunction

    // {first byte, data byte, accepted}
    localparam logic [16:0] VEC [8] = '{
        {8'h28, 8'h0A, 1'b1},
        {8'h28, 8'hFF, 1'b1},
        {8'h28, 8'hE3, 1'b1},
        {8'h28, 8'h1C, 1'b1},
        {8'h28, 8'h00, 1'b1},
        {8'h29, 8'h11, 1'b0},
        {8'h2A, 8'h12, 1'b0},
        {8'h28, 8'h1B, 1'b1}
    };

    initial begin
        int   exp_code;
        int   s0;
        logic a1, a2, s;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(code == 5'd24, "R1 code", code, 24);
        check(pull == 1'b0, "R1 pull", pull, 0);
        check(upd == 1'b0, "R1 strobe", upd, 0);
        exp_code = 24;

        for (int v = 0; v < 8; v++) begin
            logic [7:0] a = VEC[v][16:9];
            logic [7:0] d = VEC[v][8:1];
            logic       acc = VEC[v][0];
            s0 = strobes;
            write_xfer(a, d, a1, a2);
            if (acc) exp_code = sat_code(d);
            check(a1 == acc, acc ? "R2 addr ack" : "R3 addr nack", a1, acc);
            check(a2 == acc, acc ? "R4 data ack" : "R3 data ignored", a2, acc);
            check(code == exp_code, "R4 R5 code", code, exp_code);
            check(strobes - s0 == int'(acc), "R6 strobe count", strobes - s0, int'(acc));
            check(pull == 1'b0, "R10 released", pull, 0);
        end

        // R6: STOP inside the data byte
        s0 = strobes;
        bus_start();
        send_byte(8'h28, a1);
        for (int i = 0; i < 4; i++) bit_out(1'b1, s);
        bus_stop(); wq();
        check(code == exp_code, "R6 early stop code", code, exp_code);
        check(strobes == s0, "R6 early stop strobe", strobes - s0, 0);

        // R8: repeated START mid data byte
        bus_start();
        send_byte(8'h28, a1);
        for (int i = 0; i < 3; i++) bit_out(1'b1, s);
        bus_start();
        send_byte(8'h28, a1);
        send_byte(8'h05, a2);
        bus_stop(); wq();
        check(a1 && a2, "R8 acks after restart", int'(a1 & a2), 1);
        check(code == 5'd5, "R8 code", code, 5);

        // R7: second data byte refused
        bus_start();
        send_byte(8'h28, a1);
        send_byte(8'h07, a2);
        send_byte(8'h09, s);
        bus_stop(); wq();
        check(s == 1'b0, "R7 extra byte nack", s, 0);
        check(code == 5'd7, "R7 code", code, 7);

        // R9: disable
        en = 1'b0;
        repeat (3) @(negedge clk);
        check(code == 5'd24, "R9 default", code, 24);
        s0 = strobes;
        write_xfer(8'h28, 8'h03, a1, a2);
        check(a2 == 1'b1, "R9 ack while disabled", a2, 1);
        check(code == 5'd24 && strobes == s0, "R9 write discarded", code, 24);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(code == 5'd24, "R9 after re-enable", code, 24);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule